// File: doc/BRIEF.md
# Landing-Pad Expectation Tracker

This block holds the forward-edge control-flow state of one hart that runs in machine, supervisor and user privilege. After an indirect jump or call retires in a mode where checking is on, the block records that a landing pad must come next. The next retired instruction must then be a landing-pad instruction whose label matched. If it is anything else, the block raises a software-check exception request with a fault code and drops the expectation.

Checking is switched per privilege level. Machine mode follows the machine security enable. Supervisor mode follows the environment enable. When the hart has no supervisor mode, user mode follows the environment enable instead. In a mode where checking is off, the expectation bit never leaves zero and a landing-pad instruction does nothing.

Across traps the expectation bit is saved in one previous-expectation bit per trap level. On the matching return it is restored, but only if the mode being returned to has checking on. Both saved bits also appear at fixed positions of a status-register view, so a status file can merge them in.

Top module: `lpad_state_unit`

## Requirements
- R1: After reset, elp_o, spelp_o, mpelp_o, swcheck_req_o, swcheck_cause_o and pelp_status_o are all zero.
- R2: The privilege encoding is 0 = user, 1 = supervisor, 3 = machine, and 2 is never enabled. Checking is on in machine mode when sec_lp_en_i is 1. It is on in supervisor mode when env_lp_en_i is 1 and s_mode_present_i is 1. It is on in user mode when env_lp_en_i is 1 and s_mode_present_i is 0. It is off in every other case.
- R3: In a mode with checking on and with elp_o at 0, a retire with retire_indirect_i set makes elp_o 1 in the next cycle.
- R4: With elp_o at 1, a retire with retire_lpad_i and lpad_match_i both set clears elp_o in the next cycle and raises no request.
- R5: With elp_o at 1 and checking on, any other retire makes swcheck_req_o 1 for one cycle with swcheck_cause_o = 2, and clears elp_o in the same cycle. While swcheck_req_o is 0, swcheck_cause_o is 0.
- R6: In a mode with checking off, retires never raise a request. An indirect retire leaves elp_o at 0, and a landing-pad retire has no effect.
- R7: On trap entry, the current elp_o is copied into the saved bit of the target level and elp_o becomes 0. A trap_tgt_i of 3 selects mpelp_o; any other value selects spelp_o.
- R8: On trap return from a level (trap_ret_from_i 3 = machine, otherwise supervisor), elp_o takes that level's saved bit if checking is on for ret_priv_i, and 0 otherwise. The saved bit of that level is cleared.
- R9: In pelp_status_o, bit 23 equals spelp_o and bit 41 equals mpelp_o. All other bits are 0.
- R10: In one cycle, trap entry takes priority over trap return, and trap return takes priority over a retire. A retire or return that loses has no effect and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_i | input | 2 | Current privilege mode |
| s_mode_present_i | input | 1 | Hart implements supervisor mode |
| env_lp_en_i | input | 1 | Landing-pad enable for the less privileged modes |
| sec_lp_en_i | input | 1 | Landing-pad enable for machine mode |
| retire_i | input | 1 | An instruction retired this cycle |
| retire_indirect_i | input | 1 | The retired instruction is an indirect jump or call |
| retire_lpad_i | input | 1 | The retired instruction is a landing-pad instruction |
| lpad_match_i | input | 1 | The landing-pad label matched |
| trap_enter_i | input | 1 | Trap entry strobe |
| trap_tgt_i | input | 2 | Privilege level that takes the trap |
| trap_ret_i | input | 1 | Trap return strobe |
| trap_ret_from_i | input | 2 | Level whose return instruction executes |
| ret_priv_i | input | 2 | Privilege mode being returned to |
| elp_o | output | 1 | Landing pad currently expected |
| spelp_o | output | 1 | Saved expectation, supervisor level |
| mpelp_o | output | 1 | Saved expectation, machine level |
| pelp_status_o | output | STATUS_W | Status-register view holding the saved bits |
| swcheck_req_o | output | 1 | Software-check exception request |
| swcheck_cause_o | output | CAUSE_W | Trap value for the request |

## Verification
The bench goes after the enable table. If user mode were enabled while a supervisor mode exists, or if machine mode followed the environment bit, an indirect call in the wrong mode would arm elp_o. It checks both failing forms of the next instruction: a non-pad, and a pad whose label mismatched. A design that accepted either would drop the fault request, and a design with a wrong cause would report something other than 2. It saves and restores through both trap levels, including a return into a mode with checking off. A design that restored blindly would leave elp_o set there, and one that forgot to clear the saved bit would show a stale status bit. Finally, it fires an entry together with a retire, and an entry together with a return, in the same cycle. A design with the wrong priority would raise a fault or restore a stale expectation.

// File: rtl/lpad_pkg.sv
package lpad_pkg;

  localparam int unsigned PRIV_W = 2;

  typedef enum logic [PRIV_W-1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  // software-check trap values
  localparam int unsigned SWCHK_NONE     = 0;
  localparam int unsigned SWCHK_LPAD     = 2;
  localparam int unsigned SWCHK_SHADOW   = 3;

  // checking enable for one privilege mode
  function automatic logic lp_mode_enabled(input logic [PRIV_W-1:0] priv,
                                           input logic s_present,
                                           input logic env_en,
                                           input logic sec_en);
    logic en;
    case (priv)
      PRIV_M:  en = sec_en;
      PRIV_S:  en = env_en & s_present;
      PRIV_U:  en = env_en & ~s_present;
      default: en = 1'b0;
    endcase
    return en;
  endfunction

  // value of the expectation bit after a return
  function automatic logic lp_restore(input logic ret_mode_en,
                                      input logic saved_bit);
    return ret_mode_en & saved_bit;
  endfunction

  // level selector: true when a level code names machine mode
  function automatic logic lp_is_m(input logic [PRIV_W-1:0] lvl);
    return lvl == PRIV_M;
  endfunction

endpackage

// File: rtl/lpad_enable_sel.sv
module lpad_enable_sel
  import lpad_pkg::*;
(
  input  logic [PRIV_W-1:0] priv_i,
  input  logic [PRIV_W-1:0] ret_priv_i,
  input  logic              s_mode_present_i,
  input  logic              env_lp_en_i,
  input  logic              sec_lp_en_i,
  output logic              cur_en_o,
  output logic              ret_en_o
);

  assign cur_en_o = lp_mode_enabled(priv_i, s_mode_present_i,
                                    env_lp_en_i, sec_lp_en_i);
  assign ret_en_o = lp_mode_enabled(ret_priv_i, s_mode_present_i,
                                    env_lp_en_i, sec_lp_en_i);

endmodule

// File: rtl/lpad_trap_stack.sv
module lpad_trap_stack
  import lpad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_enter_i,
  input  logic [PRIV_W-1:0] enter_tgt_i,
  input  logic              ev_return_i,
  input  logic [PRIV_W-1:0] ret_from_i,
  input  logic              elp_i,
  output logic              spelp_o,
  output logic              mpelp_o,
  output logic              restore_bit_o
);

  logic spelp_q, mpelp_q, spelp_d, mpelp_d;
  logic enter_m, ret_m;

  assign enter_m = lp_is_m(enter_tgt_i);
  assign ret_m   = lp_is_m(ret_from_i);

  always_comb begin
    spelp_d = spelp_q;
    mpelp_d = mpelp_q;
    if (ev_enter_i) begin
      if (enter_m) mpelp_d = elp_i;
      else         spelp_d = elp_i;
    end else if (ev_return_i) begin
      if (ret_m) mpelp_d = 1'b0;
      else       spelp_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spelp_q <= 1'b0;
      mpelp_q <= 1'b0;
    end else begin
      spelp_q <= spelp_d;
      mpelp_q <= mpelp_d;
    end
  end

  assign restore_bit_o = ret_m ? mpelp_q : spelp_q;
  assign spelp_o = spelp_q;
  assign mpelp_o = mpelp_q;

  p_save_m_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_enter_i && enter_tgt_i == PRIV_M) |=> (mpelp_o == $past(elp_i)));

  p_save_s_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_enter_i && enter_tgt_i != PRIV_M) |=> (spelp_o == $past(elp_i) && $stable(mpelp_o)));

  p_ret_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_return_i && !ev_enter_i && ret_from_i != PRIV_M) |=> !spelp_o);

endmodule

// File: rtl/lpad_track.sv
module lpad_track
  import lpad_pkg::*;
#(
  parameter int unsigned CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cur_en_i,
  input  logic               ret_en_i,
  input  logic               restore_bit_i,
  input  logic               ev_enter_i,
  input  logic               ev_return_i,
  input  logic               retire_i,
  input  logic               indirect_i,
  input  logic               lpad_i,
  input  logic               match_i,
  output logic               elp_o,
  output logic               req_o,
  output logic [CAUSE_W-1:0] cause_o
);

  localparam logic [CAUSE_W-1:0] FAULT_CODE = CAUSE_W'(SWCHK_LPAD);
  localparam logic [CAUSE_W-1:0] NONE_CODE  = CAUSE_W'(SWCHK_NONE);

  logic elp_q, elp_d, req_q, req_d;
  logic ev_retire, ev_land, ev_fault, ev_arm;

  // named events for the checks
  assign ev_retire = retire_i & cur_en_i & ~ev_enter_i & ~ev_return_i;
  assign ev_land   = ev_retire & elp_q & lpad_i & match_i;
  assign ev_fault  = ev_retire & elp_q & ~(lpad_i & match_i);
  assign ev_arm    = ev_retire & ~elp_q & indirect_i;

  always_comb begin
    elp_d = elp_q;
    req_d = 1'b0;
    if (ev_enter_i)       elp_d = 1'b0;
    else if (ev_return_i) elp_d = lp_restore(ret_en_i, restore_bit_i);
    else if (!cur_en_i)   elp_d = 1'b0;
    else if (ev_land)     elp_d = 1'b0;
    else if (ev_fault) begin
      elp_d = 1'b0;
      req_d = 1'b1;
    end else if (ev_arm)  elp_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elp_q   <= 1'b0;
      req_q   <= 1'b0;
      cause_o <= NONE_CODE;
    end else begin
      elp_q   <= elp_d;
      req_q   <= req_d;
      cause_o <= req_d ? FAULT_CODE : NONE_CODE;
    end
  end

  assign elp_o = elp_q;
  assign req_o = req_q;

  p_fault_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (cause_o == FAULT_CODE && !elp_o));

  p_idle_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o |-> (cause_o == NONE_CODE));

  p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o || $past(elp_o));

  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_en_i && !ev_enter_i && !ev_return_i) |=> (!elp_o && !req_o));

  p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_en_i && retire_i && indirect_i && !elp_o && !ev_enter_i && !ev_return_i)
      |=> elp_o);

  p_enter_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_enter_i |=> (!elp_o && !req_o));

endmodule

// File: rtl/lpad_state_unit.sv
module lpad_state_unit
  import lpad_pkg::*;
#(
  parameter int unsigned STATUS_W  = 64,
  parameter int unsigned SPELP_POS = 23,
  parameter int unsigned MPELP_POS = 41,
  parameter int unsigned CAUSE_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          priv_i,
  input  logic                s_mode_present_i,
  input  logic                env_lp_en_i,
  input  logic                sec_lp_en_i,
  input  logic                retire_i,
  input  logic                retire_indirect_i,
  input  logic                retire_lpad_i,
  input  logic                lpad_match_i,
  input  logic                trap_enter_i,
  input  logic [1:0]          trap_tgt_i,
  input  logic                trap_ret_i,
  input  logic [1:0]          trap_ret_from_i,
  input  logic [1:0]          ret_priv_i,
  output logic                elp_o,
  output logic                spelp_o,
  output logic                mpelp_o,
  output logic [STATUS_W-1:0] pelp_status_o,
  output logic                swcheck_req_o,
  output logic [CAUSE_W-1:0]  swcheck_cause_o
);

  logic cur_en, ret_en, restore_bit;
  logic ev_enter, ev_return;

  assign ev_enter  = trap_enter_i;
  assign ev_return = trap_ret_i & ~trap_enter_i;

  lpad_enable_sel u_en (
    .priv_i           (priv_i),
    .ret_priv_i       (ret_priv_i),
    .s_mode_present_i (s_mode_present_i),
    .env_lp_en_i      (env_lp_en_i),
    .sec_lp_en_i      (sec_lp_en_i),
    .cur_en_o         (cur_en),
    .ret_en_o         (ret_en)
  );

  lpad_trap_stack u_stack (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_enter_i    (ev_enter),
    .enter_tgt_i   (trap_tgt_i),
    .ev_return_i   (ev_return),
    .ret_from_i    (trap_ret_from_i),
    .elp_i         (elp_o),
    .spelp_o       (spelp_o),
    .mpelp_o       (mpelp_o),
    .restore_bit_o (restore_bit)
  );

  lpad_track #(.CAUSE_W(CAUSE_W)) u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .cur_en_i      (cur_en),
    .ret_en_i      (ret_en),
    .restore_bit_i (restore_bit),
    .ev_enter_i    (ev_enter),
    .ev_return_i   (ev_return),
    .retire_i      (retire_i),
    .indirect_i    (retire_indirect_i),
    .lpad_i        (retire_lpad_i),
    .match_i       (lpad_match_i),
    .elp_o         (elp_o),
    .req_o         (swcheck_req_o),
    .cause_o       (swcheck_cause_o)
  );

  // place the saved bits in the status view
  for (genvar b = 0; b < STATUS_W; b++) begin : g_status
    if (b == SPELP_POS) begin : g_s
      assign pelp_status_o[b] = spelp_o;
    end else if (b == MPELP_POS) begin : g_m
      assign pelp_status_o[b] = mpelp_o;
    end else begin : g_z
      assign pelp_status_o[b] = 1'b0;
    end
  end

  p_status_sparse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pelp_status_o) == (32'(spelp_o) + 32'(mpelp_o)));

  p_ret_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ret_i && !trap_enter_i && !ret_en) |=> !elp_o);

endmodule

// File: tb/sim_lpad_state_unit.sv
module sim_lpad_state_unit;
  localparam int unsigned SW = 64;
  localparam int unsigned CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] priv = 2'd3, tgt = 2'd0, rfrom = 2'd0, rpriv = 2'd0;
  logic s_pres = 1'b1, env_en = 1'b0, sec_en = 1'b0;
  logic ret = 1'b0, ind = 1'b0, lp = 1'b0, mt = 1'b0, ent = 1'b0, tret = 1'b0;
  logic elp, spelp, mpelp, req;
  logic [SW-1:0] stat;
  logic [CW-1:0] cause;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  lpad_state_unit u0 (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .s_mode_present_i(s_pres),
    .env_lp_en_i(env_en), .sec_lp_en_i(sec_en), .retire_i(ret),
    .retire_indirect_i(ind), .retire_lpad_i(lp), .lpad_match_i(mt),
    .trap_enter_i(ent), .trap_tgt_i(tgt), .trap_ret_i(tret),
    .trap_ret_from_i(rfrom), .ret_priv_i(rpriv), .elp_o(elp),
    .spelp_o(spelp), .mpelp_o(mpelp), .pelp_status_o(stat),
    .swcheck_req_o(req), .swcheck_cause_o(cause)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] status_of(input logic s, input logic m);
    logic [SW-1:0] v = '0;
    v[23] = s;
    v[41] = m;
    return v;
  endfunction

  // one clock: pulses set before call are taken at the posedge, outputs read after
  task automatic step();
    @(negedge clk);
    ret = 0; ind = 0; lp = 0; mt = 0; ent = 0; tret = 0;
  endtask

  task automatic do_ind();   ret = 1; ind = 1; step(); endtask
  task automatic do_plain(); ret = 1; step(); endtask
  task automatic do_lpad(input logic m); ret = 1; lp = 1; mt = m; step(); endtask

  task automatic t_reset();
    chk("R1 elp", elp, 0);
    chk("R1 saved", {spelp, mpelp}, 0);
    chk("R1 req/cause", {req, cause}, 0);
    chk("R1 status", stat, 0);
  endtask

  task automatic t_arm_land();
    priv = 3; sec_en = 1;
    do_ind();
    chk("R3 arm in M", elp, 1);
    do_lpad(1);
    chk("R4 land clears", elp, 0);
    chk("R4 no req", req, 0);
  endtask

  task automatic t_fault();
    do_ind();
    do_plain();
    chk("R5 req on non-pad", req, 1);
    chk("R5 cause", cause, 2);
    chk("R5 elp cleared", elp, 0);
    step();
    chk("R5 req one cycle", {req, cause}, 0);
    do_ind();
    do_lpad(0);
    chk("R5 req on mismatch", {req, cause}, {1'b1, 4'd2});
    step();
  endtask

  task automatic t_disabled();
    priv = 3; sec_en = 0; env_en = 1;
    do_ind();
    chk("R6 no arm when off", elp, 0);
    do_plain();
    chk("R6 no req when off", req, 0);
    do_lpad(0);
    chk("R6 pad no-op", {elp, req}, 0);
  endtask

  task automatic t_enable_sel();
    s_pres = 1; env_en = 1; sec_en = 0;
    priv = 1; do_ind();
    chk("R2 S enabled", elp, 1);
    do_lpad(1);
    priv = 0; do_ind();
    chk("R2 U off with S present", elp, 0);
    s_pres = 0; do_ind();
    chk("R2 U on without S", elp, 1);
    do_lpad(1);
    priv = 2; do_ind();
    chk("R2 reserved off", elp, 0);
    priv = 3; do_ind();
    chk("R2 M ignores env bit", elp, 0);
    s_pres = 1;
  endtask

  task automatic t_traps();
    priv = 3; sec_en = 1;
    do_ind();
    ent = 1; tgt = 3; step();
    chk("R7 entry clears elp", elp, 0);
    chk("R7 saved to M", {spelp, mpelp}, 2'b01);
    chk("R9 status M bit", stat, status_of(0, 1));
    tret = 1; rfrom = 3; rpriv = 3; step();
    chk("R8 restore enabled", elp, 1);
    chk("R8 saved cleared", mpelp, 0);
    do_lpad(1);
    priv = 1; env_en = 1;
    do_ind();
    ent = 1; tgt = 1; step();
    chk("R7 saved to S", {spelp, mpelp, elp}, 3'b100);
    chk("R9 status S bit", stat, status_of(1, 0));
    tret = 1; rfrom = 1; rpriv = 0; step();
    chk("R8 return to off mode", {elp, spelp}, 0);
    priv = 0;
  endtask

  task automatic t_priority();
    priv = 1; env_en = 1; sec_en = 1;
    do_ind();
    ent = 1; tgt = 3; ret = 1; step();
    chk("R10 entry beats retire", {req, elp, mpelp}, 3'b001);
    priv = 3;
    ent = 1; tgt = 3; tret = 1; rfrom = 3; rpriv = 3; step();
    chk("R10 entry beats return", {elp, mpelp}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_arm_land();
    t_fault();
    t_disabled();
    t_enable_sel();
    t_traps();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule